// File: doc/BRIEF.md
# Virtual Address Segment Translator with Fault Capture

This block turns a 32-bit virtual address into a physical address by splitting the address space into fixed regions. Two kernel regions are translated by a fixed offset. The low user region and the top kernel region are translated through an external page-table cache (TLB). The lookup request goes out on the same cycle, and the hit, valid, dirty and frame fields come back combinationally on that cycle. An error-level flag disables translation of the low region, which then passes straight through. A user-mode flag makes every address with bit 31 set illegal.

When a request faults, the block classifies the fault as one of five exception codes. It then loads three capture registers: the full faulting address, a context word and an entry-high word. The context word is built from a kept 9-bit base and the address page-pair number. The entry-high word is built from the page number and the current 8-bit address-space identifier. The kept fields are supplied as inputs by the surrounding control logic. The response and the capture registers are registered and appear one cycle after the request.

Top module: `vaddr_seg_xlate`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `rsp_valid`, `rsp_fault`, `rsp_exc`, `rsp_paddr`, `badvaddr`, `context_reg` and `entryhi` are all zero.
- R2: In user mode, any address with bit 31 set faults with code 4 for a load or 5 for a store. No TLB request is raised, whatever the error-level flag is.
- R3: With the error-level flag set, an address below 0x80000000 gives a physical address equal to the virtual address. It gives no fault and raises no TLB request.
- R4: In kernel mode, addresses 0x80000000–0x9FFFFFFF give the address minus 0x80000000, and addresses 0xA0000000–0xBFFFFFFF give the address minus 0xA0000000. Neither region raises a TLB request.
- R5: A valid request below 0x80000000 with the error-level flag clear, or any kernel-mode request at 0xC0000000 or above, raises `tlb_req` in the same cycle with `tlb_vpn` = address bits 31:12. A valid hit then gives `rsp_paddr` = {`tlb_pfn`, address bits 11:0}.
- R6: A mapped request that misses the TLB faults with code 2 for a load or 3 for a store.
- R7: A mapped request that hits an entry whose valid bit is clear faults with code 2 for a load or 3 for a store.
- R8: A store that hits a valid entry whose dirty bit is clear faults with code 1. A load to such an entry does not fault, and a store to a dirty entry does not fault.
- R9: On a fault, `badvaddr` takes the full faulting address.
- R10: On a fault, `context_reg` becomes {`ctx_keep_in`[8:0], address bits 31:13, 4'b0000}.
- R11: On a fault, `entryhi` becomes {address bits 31:12, 4'b0000, `asid_in`[7:0]}.
- R12: The capture registers change only on the clock edge that ends a cycle carrying a valid, faulting request. Otherwise they hold their values.
- R13: `rsp_valid` is `req_valid` delayed by one cycle. On a response without a fault, `rsp_fault` is 0 and `rsp_exc` is 0. On a fault, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| mode_user | input | 1 | Request issued in user mode |
| err_level | input | 1 | Error level: low region untranslated |
| ctx_keep_in | input | 9 | Kept upper field of the context word |
| asid_in | input | 8 | Current address-space identifier |
| tlb_req | output | 1 | TLB lookup needed this cycle |
| tlb_vpn | output | 20 | Virtual page number for the lookup |
| tlb_hit | input | 1 | Lookup matched an entry |
| tlb_valid | input | 1 | Matched page is valid |
| tlb_dirty | input | 1 | Matched page is writable |
| tlb_pfn | input | 20 | Physical frame number of the match |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Response carries an exception |
| rsp_exc | output | 5 | Exception code (0 when no fault) |
| rsp_paddr | output | 32 | Physical address |
| badvaddr | output | 32 | Captured faulting address |
| context_reg | output | 32 | Captured context word |
| entryhi | output | 32 | Captured entry-high word |

## Verification
Two functions can apply on the same cycle: the user-mode check and the error-level override of the low region. When both flags are set together, the user check must still reject any address with bit 31 set, while a low address must still pass through untranslated. The bench drives both flags with low addresses, kernel-direct addresses and mapped addresses, in load and store form. It judges each case by the response code, the physical address, and whether `tlb_req` was raised during the cycle. The capture registers are then compared against a model that updates only on faulting cycles.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [4:0] {
    EXC_NONE = 5'd0,
    EXC_MOD  = 5'd1,
    EXC_TLBL = 5'd2,
    EXC_TLBS = 5'd3,
    EXC_ADEL = 5'd4,
    EXC_ADES = 5'd5
  } exc_code_e;

  typedef enum logic [2:0] {
    SEG_LOW_MAPPED,
    SEG_LOW_RAW,
    SEG_KDIRECT_C,
    SEG_KDIRECT_U,
    SEG_HIGH_MAPPED,
    SEG_ILLEGAL
  } seg_kind_e;

endpackage

// File: rtl/seg_classify.sv
module seg_classify
  import xlate_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic [VA_W-1:0] va,
  input  logic            user,
  input  logic            erl,
  output seg_kind_e       kind,
  output logic [VA_W-1:0] direct_pa
);

  localparam int TOP_W = 3;
  localparam int LOW_W = VA_W - TOP_W;

  logic [TOP_W-1:0] top;
  assign top = va[VA_W-1 -: TOP_W];

  always_comb begin
    kind      = SEG_HIGH_MAPPED;
    direct_pa = va;
    if (user && va[VA_W-1]) begin
      kind = SEG_ILLEGAL;
    end else if (!va[VA_W-1]) begin
      kind = erl ? SEG_LOW_RAW : SEG_LOW_MAPPED;
    end else begin
      unique case (top)
        3'b100: begin
          kind      = SEG_KDIRECT_C;
          direct_pa = {{TOP_W{1'b0}}, va[LOW_W-1:0]};
        end
        3'b101: begin
          kind      = SEG_KDIRECT_U;
          direct_pa = {{TOP_W{1'b0}}, va[LOW_W-1:0]};
        end
        default: kind = SEG_HIGH_MAPPED;
      endcase
    end
  end

endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import xlate_pkg::*;
#(
  parameter int PFN_W = 20,
  parameter int OFF_W = 12
) (
  input  logic                   is_store,
  input  logic                   hit,
  input  logic                   valid,
  input  logic                   dirty,
  input  logic [PFN_W-1:0]       pfn,
  input  logic [OFF_W-1:0]       offset,
  output exc_code_e              exc,
  output logic [PFN_W+OFF_W-1:0] pa
);

  assign pa = {pfn, offset};

  always_comb begin
    if (!hit || !valid) begin
      exc = is_store ? EXC_TLBS : EXC_TLBL;
    end else if (is_store && !dirty) begin
      exc = EXC_MOD;
    end else begin
      exc = EXC_NONE;
    end
  end

endmodule

// File: rtl/fault_regs.sv
module fault_regs #(
  parameter int VA_W       = 32,
  parameter int OFF_W      = 12,
  parameter int ASID_W     = 8,
  parameter int CTX_KEEP_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  capture,
  input  logic [VA_W-1:0]       va,
  input  logic [CTX_KEEP_W-1:0] ctx_keep,
  input  logic [ASID_W-1:0]     asid,
  output logic [VA_W-1:0]       badvaddr,
  output logic [VA_W-1:0]       context_q,
  output logic [VA_W-1:0]       entryhi
);

  localparam int PAIR_W = VA_W - OFF_W - 1;
  localparam int CPAD_W = VA_W - CTX_KEEP_W - PAIR_W;
  localparam int EPAD_W = OFF_W - ASID_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      badvaddr  <= '0;
      context_q <= '0;
      entryhi   <= '0;
    end else if (capture) begin
      badvaddr  <= va;
      context_q <= {ctx_keep, va[VA_W-1:OFF_W+1], {CPAD_W{1'b0}}};
      entryhi   <= {va[VA_W-1:OFF_W], {EPAD_W{1'b0}}, asid};
    end
  end

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !capture |=> ($stable(badvaddr) && $stable(context_q) && $stable(entryhi))); // R12
  AST_BADADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
    capture |=> (badvaddr == $past(va))); // R9

endmodule

// File: rtl/vaddr_seg_xlate.sv
module vaddr_seg_xlate
  import xlate_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int OFF_W      = 12,
  parameter int ASID_W     = 8,
  parameter int CTX_KEEP_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic                    req_store,
  input  logic                    mode_user,
  input  logic                    err_level,
  input  logic [CTX_KEEP_W-1:0]   ctx_keep_in,
  input  logic [ASID_W-1:0]       asid_in,
  output logic                    tlb_req,
  output logic [VA_W-OFF_W-1:0]   tlb_vpn,
  input  logic                    tlb_hit,
  input  logic                    tlb_valid,
  input  logic                    tlb_dirty,
  input  logic [VA_W-OFF_W-1:0]   tlb_pfn,
  output logic                    rsp_valid,
  output logic                    rsp_fault,
  output logic [4:0]              rsp_exc,
  output logic [VA_W-1:0]         rsp_paddr,
  output logic [VA_W-1:0]         badvaddr,
  output logic [VA_W-1:0]         context_reg,
  output logic [VA_W-1:0]         entryhi
);

  localparam int PFN_W = VA_W - OFF_W;

  seg_kind_e        kind;
  logic [VA_W-1:0]  direct_pa;
  exc_code_e        tlb_exc;
  logic [VA_W-1:0]  tlb_pa;
  exc_code_e        exc_n;
  logic [VA_W-1:0]  pa_n;
  logic             mapped;
  logic             fault_n;
  logic             capture;

  seg_classify #(.VA_W(VA_W)) u_classify (
    .va        (req_vaddr),
    .user      (mode_user),
    .erl       (err_level),
    .kind      (kind),
    .direct_pa (direct_pa)
  );

  tlb_resolve #(.PFN_W(PFN_W), .OFF_W(OFF_W)) u_resolve (
    .is_store (req_store),
    .hit      (tlb_hit),
    .valid    (tlb_valid),
    .dirty    (tlb_dirty),
    .pfn      (tlb_pfn),
    .offset   (req_vaddr[OFF_W-1:0]),
    .exc      (tlb_exc),
    .pa       (tlb_pa)
  );

  assign mapped  = (kind == SEG_LOW_MAPPED) || (kind == SEG_HIGH_MAPPED);
  assign tlb_req = req_valid && mapped;
  assign tlb_vpn = req_vaddr[VA_W-1:OFF_W];

  always_comb begin
    if (kind == SEG_ILLEGAL) begin
      exc_n = req_store ? EXC_ADES : EXC_ADEL;
      pa_n  = direct_pa;
    end else if (mapped) begin
      exc_n = tlb_exc;
      pa_n  = tlb_pa;
    end else begin
      exc_n = EXC_NONE;
      pa_n  = direct_pa;
    end
  end

  assign fault_n = (exc_n != EXC_NONE);
  assign capture = req_valid && fault_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_exc   <= 5'd0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= capture;
      rsp_exc   <= req_valid ? exc_n : EXC_NONE;
      rsp_paddr <= (req_valid && !fault_n) ? pa_n : '0;
    end
  end

  fault_regs #(
    .VA_W(VA_W), .OFF_W(OFF_W), .ASID_W(ASID_W), .CTX_KEEP_W(CTX_KEEP_W)
  ) u_fault (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .va        (req_vaddr),
    .ctx_keep  (ctx_keep_in),
    .asid      (asid_in),
    .badvaddr  (badvaddr),
    .context_q (context_reg),
    .entryhi   (entryhi)
  );

  AST_USER_HIGH_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_user && req_vaddr[VA_W-1]) |=>
      (rsp_fault && (rsp_exc == 5'd4 || rsp_exc == 5'd5))); // R2
  AST_USER_HIGH_NO_TLB: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_user && req_vaddr[VA_W-1]) |-> !tlb_req); // R2
  AST_ERL_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (req_valid && err_level && !req_vaddr[VA_W-1]) |=>
      (!rsp_fault && rsp_paddr == $past(req_vaddr))); // R3
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R13

endmodule

// File: tb/vaddr_seg_xlate_tb.sv
`timescale 1ns/1ps
module vaddr_seg_xlate_tb;

  typedef struct packed {
    logic [23:0] rq;
    logic [31:0] va;
    logic        st;
    logic        usr;
    logic        erl;
    logic        hit;
    logic        vld;
    logic        drt;
    logic [19:0] pfn;
    logic        treq;
    logic        flt;
    logic [4:0]  exc;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{"R5 ", 32'h0040_1234, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h12345, 1'b1, 1'b0, 5'd0, 32'h1234_5234},
    '{"R8 ", 32'h0040_1234, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 20'h00ABC, 1'b1, 1'b0, 5'd0, 32'h00AB_C234},
    '{"R8 ", 32'h0040_1234, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00ABC, 1'b1, 1'b1, 5'd1, 32'h0000_0000},
    '{"R6 ", 32'h1000_0008, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 20'h00001, 1'b1, 1'b1, 5'd2, 32'h0000_0000},
    '{"R6 ", 32'h1000_0008, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 20'h00001, 1'b1, 1'b1, 5'd3, 32'h0000_0000},
    '{"R7 ", 32'hC000_2000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h00002, 1'b1, 1'b1, 5'd2, 32'h0000_0000},
    '{"R7 ", 32'hE123_4567, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h00003, 1'b1, 1'b1, 5'd3, 32'h0000_0000},
    '{"R4 ", 32'h8123_4567, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0, 5'd0, 32'h0123_4567},
    '{"R4 ", 32'hBFFF_FFFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0, 5'd0, 32'h1FFF_FFFC},
    '{"R4 ", 32'hA000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0, 5'd0, 32'h0000_0000},
    '{"R5 ", 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00007, 1'b1, 1'b0, 5'd0, 32'h0000_7FFF},
    '{"R2 ", 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 20'h00000, 1'b0, 1'b1, 5'd4, 32'h0000_0000},
    '{"R2 ", 32'hF000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 20'h00000, 1'b0, 1'b1, 5'd5, 32'h0000_0000},
    '{"R3 ", 32'h7000_0010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0, 5'd0, 32'h7000_0010},
    '{"R3 ", 32'h7000_0010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0, 5'd0, 32'h7000_0010},
    '{"R2 ", 32'h9FFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 20'h00000, 1'b0, 1'b1, 5'd5, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_store;
  logic        mode_user;
  logic        err_level;
  logic [8:0]  ctx_keep_in;
  logic [7:0]  asid_in;
  logic        tlb_req;
  logic [19:0] tlb_vpn;
  logic        tlb_hit;
  logic        tlb_valid;
  logic        tlb_dirty;
  logic [19:0] tlb_pfn;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [4:0]  rsp_exc;
  logic [31:0] rsp_paddr;
  logic [31:0] badvaddr;
  logic [31:0] context_reg;
  logic [31:0] entryhi;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] m_bad, m_ctx, m_eh;

  always #4 clk = ~clk;

  vaddr_seg_xlate u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_store(req_store), .mode_user(mode_user), .err_level(err_level),
    .ctx_keep_in(ctx_keep_in), .asid_in(asid_in), .tlb_req(tlb_req),
    .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit), .tlb_valid(tlb_valid),
    .tlb_dirty(tlb_dirty), .tlb_pfn(tlb_pfn), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_exc(rsp_exc), .rsp_paddr(rsp_paddr),
    .badvaddr(badvaddr), .context_reg(context_reg), .entryhi(entryhi)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic model_fault(input logic [31:0] va);
    m_bad = va;
    m_ctx = {ctx_keep_in, va[31:13], 4'b0000};
    m_eh  = {va[31:12], 4'b0000, asid_in};
  endtask

  task automatic check_regs(input string rq);
    chk(rq, "badvaddr", badvaddr, m_bad);
    chk(rq, "context", context_reg, m_ctx);
    chk(rq, "entryhi", entryhi, m_eh);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_store = 1'b0;
    mode_user = 1'b0; err_level = 1'b0; ctx_keep_in = 9'h1A5; asid_in = 8'h3C;
    tlb_hit = 1'b0; tlb_valid = 1'b0; tlb_dirty = 1'b0; tlb_pfn = '0;
    m_bad = '0; m_ctx = '0; m_eh = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1", "rsp_fault", {31'b0, rsp_fault}, 32'd0);
    chk("R1", "rsp_exc", {27'b0, rsp_exc}, 32'd0);
    chk("R1", "rsp_paddr", rsp_paddr, 32'd0);
    check_regs("R1");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", "rsp_valid after release", {31'b0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1'b1;  req_vaddr = VEC[i].va;  req_store = VEC[i].st;
      mode_user = VEC[i].usr; err_level = VEC[i].erl;
      tlb_hit = VEC[i].hit; tlb_valid = VEC[i].vld; tlb_dirty = VEC[i].drt;
      tlb_pfn = VEC[i].pfn;
      #1;
      chk(VEC[i].rq, "tlb_req", {31'b0, tlb_req}, {31'b0, VEC[i].treq});
      if (VEC[i].treq) chk("R5", "tlb_vpn", {12'b0, tlb_vpn}, {12'b0, VEC[i].va[31:12]});
      if (VEC[i].flt) model_fault(VEC[i].va);
      @(posedge clk); #1;
      chk("R13", "rsp_valid", {31'b0, rsp_valid}, 32'd1);
      chk(VEC[i].rq, "rsp_fault", {31'b0, rsp_fault}, {31'b0, VEC[i].flt});
      chk(VEC[i].rq, "rsp_exc", {27'b0, rsp_exc}, {27'b0, VEC[i].exc});
      chk(VEC[i].rq, "rsp_paddr", rsp_paddr, VEC[i].pa);
      check_regs(VEC[i].flt ? "R9" : "R12");
    end

    // R12: an idle cycle with a fault-shaped address leaves the capture state alone
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = 32'hDEAD_B000; mode_user = 1'b1; req_store = 1'b1;
    ctx_keep_in = 9'h0F3; asid_in = 8'h81;
    @(posedge clk); #1;
    chk("R13", "rsp_valid idle", {31'b0, rsp_valid}, 32'd0);
    chk("R13", "rsp_exc idle", {27'b0, rsp_exc}, 32'd0);
    check_regs("R12");

    // R10 / R11: new kept fields appear in the captured words
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'hFFFF_E123; mode_user = 1'b1; req_store = 1'b0;
    err_level = 1'b0;
    model_fault(32'hFFFF_E123);
    @(posedge clk); #1;
    chk("R2", "rsp_exc user top", {27'b0, rsp_exc}, 32'd4);
    chk("R10", "context", context_reg, 32'h79FF_FFF0);
    chk("R11", "entryhi", entryhi, 32'hFFFF_E081);
    check_regs("R9");

    // R12: a good request right after a fault keeps the captured words
    @(negedge clk);
    mode_user = 1'b0; req_vaddr = 32'h8000_0040;
    @(posedge clk); #1;
    chk("R4", "rsp_paddr", rsp_paddr, 32'h0000_0040);
    check_regs("R12");

    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    finish_run();
  end

endmodule